// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block connects a pair of parallel 24-bit sample registers to a three-wire serial audio bus made of a bit clock, a frame clock and one data line in each direction. On every frame it shifts out a left/right sample pair from `tx_left_i`/`tx_right_i` and gathers an incoming pair, which it presents on `rx_left_o`/`rx_right_o` with a one-cycle strobe. Four frame layouts are supported: I2S, left-justified, right-justified and a DSP layout in which both channels are packed back to back after a short frame pulse. The word length on the wire is selectable. The core width stays fixed at 24 bits, so words are truncated or zero-filled at the edge of the block.

The port runs from a fast system clock `clk`. As bus master it generates the bit clock (one half period every `HALF_DIV` system clocks) and a frame clock of 32 bit clocks per channel. As bus slave it takes both clocks from its pins. Bus clocks are synchronised into `clk` and acted on at their detected edges, so a bit-clock half period has to last at least six system clocks. When `active_i` is low, every bus output enable is low and the transfer state is cleared. Configuration is meant to change only while the port is inactive.

Top module: `afmt_serial_port`

## Requirements
- R1: `fmt_i` picks the layout: 0 = I2S (MSB in the second bit slot after a frame-clock change, left channel while the frame clock is low), 1 = left-justified (MSB in the first bit slot after a change, left while high), 2 = right-justified (the word occupies the last bit slots of each 32-slot half, left while high), 3 = DSP (a frame starts when the frame clock rises).
- R2: `wlen_i` sets the word length on the wire: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits.
- R3: On transmit a word shorter than 24 bits carries the upper bits of the sample, MSB first, and drops the low-order bits. A 32-bit word carries all 24 sample bits followed by 8 zeros.
- R4: On receive, a word shorter than 24 bits fills the upper bits of the 24-bit result and leaves the low bits zero. For a 32-bit word the last 8 bits are discarded.
- R5: In right-justified layout a 32-bit selection behaves exactly as a 24-bit one.
- R6: In DSP layout `dsp_phase_i` = 0 puts the left MSB in the first bit slot after the frame clock rises, and 1 puts it in the second. The right word starts in the slot right after the last left bit.
- R7: With `master_i` = 1 and active, the block drives the bit clock (half period `HALF_DIV` clocks, 64 bit clocks per frame) and the frame clock, and the frame clock changes only when the bit clock falls. With `master_i` = 0 both clock output enables stay low and the pins `bclk_i`/`lrclk_i` time the transfer.
- R8: While `active_i` is low, `bclk_oe_o`, `lrclk_oe_o` and `sdout_oe_o` are low, `sdout_o` is 0 and no strobe is produced.
- R9: Incoming data is taken at rising bit-clock edges. Outgoing data changes only after falling bit-clock edges and is steady across every rising edge.
- R10: Bit slots outside the transmitted words carry 0.
- R11: `rx_valid_o` is a single-cycle pulse, exactly once per frame, after the right word has been received.
- R12: After reset the strobe is low and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Enables the port |
| master_i | input | 1 | 1 = generate bus clocks, 0 = follow them |
| fmt_i | input | 2 | Frame layout select (R1) |
| wlen_i | input | 2 | Word length select (R2) |
| dsp_phase_i | input | 1 | DSP MSB slot select (R6) |
| bclk_i | input | 1 | Bit clock from the bus (slave) |
| lrclk_i | input | 1 | Frame clock from the bus (slave) |
| sdin_i | input | 1 | Serial data in |
| tx_left_i | input | 24 | Left sample to send |
| tx_right_i | input | 24 | Right sample to send |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe_o | output | 1 | Output enable for the bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| lrclk_oe_o | output | 1 | Output enable for the frame clock |
| sdout_o | output | 1 | Serial data out |
| sdout_oe_o | output | 1 | Output enable for the data out |
| rx_left_o | output | 24 | Last received left sample |
| rx_right_o | output | 24 | Last received right sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
On every cycle the assertions check that the strobe never lasts two cycles and always follows a sampling edge, that the data line is steady over rising bit-clock edges, that an inactive port clears its data line and strobe, and that a generated frame clock moves only when the bit clock falls. Bit placement in each layout, truncation and zero-fill at each word length, the right-justified 32-bit fallback, both DSP phases and slave timing can only be shown by the bench scenarios. These loop the data line back, compare whole captured frames against layouts computed from the requirements, and compare the received pairs.

// File: rtl/afmt_pkg.sv
`timescale 1ns/1ps
package afmt_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } afmt_fmt_e;

    // Bits per word on the wire; right-justified falls back from 32 to 24.
    function automatic logic [6:0] eff_len(input afmt_fmt_e f, input logic [1:0] wsel);
        logic [6:0] w;
        case (wsel)
            2'd0:    w = 7'd16;
            2'd1:    w = 7'd20;
            2'd2:    w = 7'd24;
            default: w = 7'd32;
        endcase
        if (f == FMT_RJ && w == 7'd32) w = 7'd24;
        return w;
    endfunction

endpackage

// File: rtl/afmt_edge.sv
`timescale 1ns/1ps
module afmt_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sd_i,
    output logic rise_o,
    output logic fall_o,
    output logic lr_o,
    output logic sd_o
);
    typedef struct packed {
        logic [SYNC-1:0] b_sh;
        logic [SYNC-1:0] l_sh;
        logic [SYNC-1:0] d_sh;
        logic            b_last;
        logic            fall_dly;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     b_now;

    assign b_now = st_q.b_sh[SYNC-1];

    always_comb begin
        st_d          = st_q;
        st_d.b_sh     = {st_q.b_sh[SYNC-2:0], bclk_i};
        st_d.l_sh     = {st_q.l_sh[SYNC-2:0], lrclk_i};
        st_d.d_sh     = {st_q.d_sh[SYNC-2:0], sd_i};
        st_d.b_last   = b_now;
        // falling edge acted on one cycle late so the frame clock has settled
        st_d.fall_dly = st_q.b_last & ~b_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = b_now & ~st_q.b_last;
    assign fall_o = st_q.fall_dly;
    assign lr_o   = st_q.l_sh[SYNC-1];
    assign sd_o   = st_q.d_sh[SYNC-1];

endmodule

// File: rtl/afmt_clkgen.sv
`timescale 1ns/1ps
module afmt_clkgen
    import afmt_pkg::*;
#(
    parameter int HALF_DIV = 8,
    parameter int SLOT     = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  afmt_fmt_e fmt_i,
    output logic      bclk_o,
    output logic      lrclk_o
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam int CNT_W = $clog2(2 * SLOT);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
        logic [CNT_W-1:0] cnt;
        logic             lr;
    } gen_st_t;

    gen_st_t st_d, st_q;

    function automatic logic lr_level(input afmt_fmt_e f, input logic [CNT_W-1:0] c);
        case (f)
            FMT_I2S: return c[CNT_W-1];
            FMT_DSP: return (c == '0);
            default: return ~c[CNT_W-1];
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (st_q.div == DIV_LAST) begin
            st_d.div  = '0;
            st_d.bclk = ~st_q.bclk;
            if (st_q.bclk) begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.lr  = lr_level(fmt_i, st_d.cnt);
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o  = st_q.bclk;
    assign lrclk_o = st_q.lr;

    AST_LR_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && (st_q.lr != $past(st_q.lr))) |-> ($past(st_q.bclk) && !st_q.bclk)) // R7
        else $error("frame clock moved away from a bit-clock fall");

endmodule

// File: rtl/afmt_engine.sv
`timescale 1ns/1ps
module afmt_engine
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT     = 32,
    parameter int MAX_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  afmt_fmt_e           fmt_i,
    input  logic [1:0]          wsel_i,
    input  logic                phase_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                lr_i,
    input  logic                sd_i,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    output logic                sd_o,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    output logic                rx_valid_o
);
    localparam int POS_W = $clog2(2 * SLOT) + 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic                lr_last;
        logic                ch;
        logic [POS_W-1:0]    pos;
        logic [SAMPLE_W-1:0] txl;
        logic [SAMPLE_W-1:0] txr;
        logic [MAX_W-1:0]    accl;
        logic [MAX_W-1:0]    accr;
        logic                sd;
        logic [SAMPLE_W-1:0] rxl;
        logic [SAMPLE_W-1:0] rxr;
        logic                valid;
    } eng_st_t;

    eng_st_t          st_d, st_q;
    logic [6:0]       wlen;
    logic [6:0]       last_k;
    logic             hit, right, edge_seen;
    logic [POS_W-1:0] k;
    logic [SAMPLE_W-1:0] shifted;
    logic [MAX_W-1:0]    bit_mask;

    assign wlen   = eff_len(fmt_i, wsel_i);
    assign last_k = (int'(wlen) > SAMPLE_W) ? 7'(SAMPLE_W - 1) : wlen - 7'd1;

    // Map a bit slot to (in word?, channel, index from MSB).
    function automatic void locate(input afmt_fmt_e f, input int w, input logic ph,
                                   input logic [POS_W-1:0] p, input logic ch,
                                   output logic h, output logic r, output logic [POS_W-1:0] kk);
        int start, rel;
        case (f)
            FMT_I2S: start = 1;
            FMT_LJ:  start = 0;
            FMT_RJ:  start = SLOT - w;
            default: start = int'(ph);
        endcase
        rel = int'(p) - start;
        h   = 1'b0;
        r   = ch;
        kk  = '0;
        if (f == FMT_DSP) begin
            if (rel >= 0 && rel < w) begin
                h = 1'b1; r = 1'b0; kk = POS_W'(rel);
            end else if (rel >= w && rel < 2 * w) begin
                h = 1'b1; r = 1'b1; kk = POS_W'(rel - w);
            end
        end else if (rel >= 0 && rel < w) begin
            h  = 1'b1;
            kk = POS_W'(rel);
        end
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        hit        = 1'b0;
        right      = 1'b0;
        k          = '0;
        edge_seen  = 1'b0;
        shifted    = '0;
        bit_mask   = '0;
        if (!active_i) begin
            st_d.lr_last = 1'b0;
            st_d.ch      = 1'b0;
            st_d.pos     = POS_MAX;
            st_d.accl    = '0;
            st_d.accr    = '0;
            st_d.sd      = 1'b0;
        end else if (fall_i) begin
            edge_seen    = (fmt_i == FMT_DSP) ? (lr_i & ~st_q.lr_last) : (lr_i != st_q.lr_last);
            st_d.lr_last = lr_i;
            if (edge_seen) begin
                st_d.pos = '0;
                st_d.ch  = (fmt_i == FMT_I2S) ? lr_i : ~lr_i;
            end else if (st_q.pos != POS_MAX) begin
                st_d.pos = st_q.pos + 1'b1;
            end
            if (edge_seen && (fmt_i == FMT_DSP || !st_d.ch)) begin
                st_d.txl = tx_left_i;
                st_d.txr = tx_right_i;
            end
            locate(fmt_i, int'(wlen), phase_i, st_d.pos, st_d.ch, hit, right, k);
            shifted = (right ? st_d.txr : st_d.txl) << k;
            st_d.sd = hit && (int'(k) < SAMPLE_W) && shifted[SAMPLE_W-1];
        end else if (rise_i) begin
            locate(fmt_i, int'(wlen), phase_i, st_q.pos, st_q.ch, hit, right, k);
            bit_mask = MAX_W'(sd_i) << (POS_W'(MAX_W - 1) - k);
            if (hit) begin
                if (right) st_d.accr = ((k == '0) ? '0 : st_q.accr) | bit_mask;
                else       st_d.accl = ((k == '0) ? '0 : st_q.accl) | bit_mask;
                if (right && k == POS_W'(last_k)) begin
                    st_d.rxl   = st_q.accl[MAX_W-1 -: SAMPLE_W];
                    st_d.rxr   = st_d.accr[MAX_W-1 -: SAMPLE_W];
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= POS_MAX;
        end else begin
            st_q     <= st_d;
        end
    end

    assign sd_o       = st_q.sd;
    assign rx_left_o  = st_q.rxl;
    assign rx_right_o = st_q.rxr;
    assign rx_valid_o = st_q.valid;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid) // R11
        else $error("strobe held for two cycles");

    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(rise_i)) // R9
        else $error("strobe without a sampling edge");

    AST_TX_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && active_i) |=> (st_q.sd == $past(st_q.sd))) // R9
        else $error("data line moved at a rising edge");

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!st_q.sd && !st_q.valid)) // R8
        else $error("inactive port still driving");

endmodule

// File: rtl/afmt_serial_port.sv
`timescale 1ns/1ps
module afmt_serial_port
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT     = 32,
    parameter int MAX_W    = 32,
    parameter int HALF_DIV = 8,
    parameter int SYNC     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                master_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                dsp_phase_i,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdin_i,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    output logic                bclk_o,
    output logic                bclk_oe_o,
    output logic                lrclk_o,
    output logic                lrclk_oe_o,
    output logic                sdout_o,
    output logic                sdout_oe_o,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    output logic                rx_valid_o
);
    afmt_fmt_e fmt;
    logic      run_master;
    logic      gen_bclk, gen_lr;
    logic      src_bclk, src_lr;
    logic      rise, fall, lr_s, sd_s;

    assign fmt        = afmt_fmt_e'(fmt_i);
    assign run_master = active_i & master_i;

    afmt_clkgen #(.HALF_DIV(HALF_DIV), .SLOT(SLOT)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_master),
        .fmt_i   (fmt),
        .bclk_o  (gen_bclk),
        .lrclk_o (gen_lr)
    );

    assign src_bclk = master_i ? gen_bclk : bclk_i;
    assign src_lr   = master_i ? gen_lr   : lrclk_i;

    afmt_edge #(.SYNC(SYNC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (src_bclk),
        .lrclk_i (src_lr),
        .sd_i    (sdin_i),
        .rise_o  (rise),
        .fall_o  (fall),
        .lr_o    (lr_s),
        .sd_o    (sd_s)
    );

    afmt_engine #(.SAMPLE_W(SAMPLE_W), .SLOT(SLOT), .MAX_W(MAX_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active_i),
        .fmt_i      (fmt),
        .wsel_i     (wlen_i),
        .phase_i    (dsp_phase_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .lr_i       (lr_s),
        .sd_i       (sd_s),
        .tx_left_i  (tx_left_i),
        .tx_right_i (tx_right_i),
        .sd_o       (sdout_o),
        .rx_left_o  (rx_left_o),
        .rx_right_o (rx_right_o),
        .rx_valid_o (rx_valid_o)
    );

    assign bclk_o     = gen_bclk;
    assign lrclk_o    = gen_lr;
    assign bclk_oe_o  = run_master;
    assign lrclk_oe_o = run_master;
    assign sdout_oe_o = active_i;

endmodule

// File: tb/afmt_serial_port_bench.sv
`timescale 1ns/1ps
module afmt_serial_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active = 1'b0;
    logic        master = 1'b1;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd2;
    logic        phase = 1'b0;
    logic        bclk_drv = 1'b0;
    logic        lr_drv = 1'b0;
    logic        slave_run = 1'b0;
    logic [23:0] txl = '0, txr = '0;
    logic        sdin;
    logic        bclk_o, bclk_oe, lrclk_o, lrclk_oe, sdout, sdout_oe, rx_valid;
    logic [23:0] rxl, rxr;
    logic        bus_b, bus_lr;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign sdin   = sdout;               // loopback of the data line
    assign bus_b  = master ? bclk_o  : bclk_drv;
    assign bus_lr = master ? lrclk_o : lr_drv;

    afmt_serial_port u_afmt_serial_port (
        .clk(clk), .rst_n(rst_n), .active_i(active), .master_i(master),
        .fmt_i(fmt), .wlen_i(wlen), .dsp_phase_i(phase),
        .bclk_i(bclk_drv), .lrclk_i(lr_drv), .sdin_i(sdin),
        .tx_left_i(txl), .tx_right_i(txr),
        .bclk_o(bclk_o), .bclk_oe_o(bclk_oe), .lrclk_o(lrclk_o), .lrclk_oe_o(lrclk_oe),
        .sdout_o(sdout), .sdout_oe_o(sdout_oe),
        .rx_left_o(rxl), .rx_right_o(rxr), .rx_valid_o(rx_valid)
    );

    // Bench-side bus master for slave tests: 8-clock half periods, 32 slots per channel.
    int s_div = 0;
    int s_cnt = 0;
    always @(negedge clk) begin
        if (!slave_run) begin
            s_div = 0; s_cnt = 0; bclk_drv <= 1'b0; lr_drv <= 1'b0;
        end else if (s_div == 7) begin
            s_div = 0;
            if (bclk_drv) begin
                s_cnt = (s_cnt + 1) % 64;
                lr_drv <= (fmt == 2'd0) ? (s_cnt >= 32) : (fmt == 2'd3) ? (s_cnt == 0) : (s_cnt < 32);
            end
            bclk_drv <= ~bclk_drv;
        end else begin
            s_div = s_div + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int wlen_bits(input logic [1:0] f, input logic [1:0] ws);
        int w;
        w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 20 : (ws == 2'd2) ? 24 : 32;
        if (f == 2'd2 && w == 32) w = 24;   // R5 fallback
        return w;
    endfunction

    function automatic logic wbit(input logic [23:0] s, input int k);
        return (k < 24) ? s[23-k] : 1'b0;
    endfunction

    // Expected bit per slot, slot 0 = first rising edge of the frame (R1, R3, R6, R10)
    function automatic logic [63:0] exp_frame(input logic [1:0] f, input logic [1:0] ws, input logic ph,
                                              input logic [23:0] l, input logic [23:0] r);
        logic [63:0] v;
        int w;
        w = wlen_bits(f, ws);
        v = '0;
        for (int i = 0; i < 64; i++) begin
            int k, st;
            if (f == 2'd3) begin
                k = i - int'(ph);
                if (k >= 0 && k < w)            v[i] = wbit(l, k);
                else if (k >= w && k < 2 * w)   v[i] = wbit(r, k - w);
            end else begin
                st = (f == 2'd0) ? 1 : (f == 2'd1) ? 0 : 32 - w;
                k  = (i % 32) - st;
                if (k >= 0 && k < w) v[i] = wbit((i >= 32) ? r : l, k);
            end
        end
        return v;
    endfunction

    function automatic logic [23:0] exp_rx(input logic [23:0] s, input int w);
        return (w >= 24) ? s : (s & (24'hFFFFFF << (24 - w)));
    endfunction

    task automatic capture_frame(output logic [63:0] v);
        logic pb, plr, started;
        int i;
        pb = bus_b; plr = bus_lr; started = 1'b0; i = 0; v = '0;
        while (i < 64) begin
            @(negedge clk);
            if (bus_b && !pb) begin
                if (!started) begin
                    if ((fmt == 2'd0) ? (!bus_lr && plr) : (bus_lr && !plr)) begin
                        started = 1'b1; v[0] = sdout; i = 1;
                    end
                end else begin
                    v[i] = sdout; i++;
                end
                plr = bus_lr;
            end
            pb = bus_b;
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!rx_valid);
    endtask

    task automatic run_case(input logic [1:0] f, input logic [1:0] ws, input logic ph,
                            input logic [23:0] l, input logic [23:0] r, input string tag);
        logic [63:0] got, exp;
        int w;
        active = 1'b0;
        repeat (20) @(negedge clk);
        fmt = f; wlen = ws; phase = ph; txl = l; txr = r;
        @(negedge clk);
        active = 1'b1;
        capture_frame(got);
        capture_frame(got);
        exp = exp_frame(f, ws, ph, l, r);
        chk(got == exp, {tag, " frame"}, got, exp);
        wait_valid();
        wait_valid();
        w = wlen_bits(f, ws);
        chk(rxl == exp_rx(l, w), {tag, " rx left R4"}, 64'(rxl), 64'(exp_rx(l, w)));
        chk(rxr == exp_rx(r, w), {tag, " rx right R4"}, 64'(rxr), 64'(exp_rx(r, w)));
    endtask

    // {fmt, wlen, phase, left, right}
    localparam logic [52:0] VEC [10] = '{
        {2'd0, 2'd2, 1'b0, 24'hA5C3F1, 24'h5A3C0E},  // R1 I2S 24
        {2'd1, 2'd0, 1'b0, 24'h8001FF, 24'h7FFE01},  // R1 R3 LJ 16
        {2'd2, 2'd1, 1'b0, 24'hC0FFEE, 24'h123456},  // R1 RJ 20
        {2'd2, 2'd3, 1'b0, 24'h876543, 24'hFEDCBA},  // R5 RJ 32 acts as 24
        {2'd3, 2'd2, 1'b0, 24'hF0F0F0, 24'h0F0F0F},  // R6 DSP phase 0
        {2'd3, 2'd0, 1'b1, 24'hABCDEF, 24'h13579B},  // R6 DSP phase 1, 16 bit
        {2'd1, 2'd3, 1'b0, 24'h800001, 24'hFFFFFF},  // R3 LJ 32 zero tail
        {2'd0, 2'd1, 1'b0, 24'h40001F, 24'hC0000F},  // R4 I2S 20 low bits lost
        {2'd3, 2'd3, 1'b0, 24'h9ABCDE, 24'h765432},  // R2 DSP 32 full frame
        {2'd0, 2'd3, 1'b0, 24'h5555AA, 24'hAA5555}   // R2 I2S 32
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!rx_valid && !bclk_oe && !lrclk_oe && !sdout_oe, "R12 reset outputs",
            64'({rx_valid, bclk_oe, lrclk_oe, sdout_oe}), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            run_case(VEC[v][52:51], VEC[v][50:49], VEC[v][48], VEC[v][47:24], VEC[v][23:0],
                     $sformatf("R1 vec%0d", v));
        end

        // R7 master enables while running
        chk(bclk_oe && lrclk_oe && sdout_oe, "R7 master enables", 64'({bclk_oe, lrclk_oe, sdout_oe}), 64'd7);

        // R11 exactly one strobe per frame (1024 clocks)
        run_case(2'd1, 2'd2, 1'b0, 24'h123ABC, 24'hDEF456, "R11 prep");
        pulses = 0;
        for (int c = 0; c < 4096; c++) begin
            @(negedge clk);
            if (rx_valid) pulses++;
        end
        chk(pulses == 4, "R11 strobes in 4 frames", 64'(pulses), 64'd4);

        // R8 inactive: no enables, data low, no strobe
        active = 1'b0;
        repeat (4) @(negedge clk);
        chk(!bclk_oe && !lrclk_oe && !sdout_oe && !sdout, "R8 idle outputs",
            64'({bclk_oe, lrclk_oe, sdout_oe, sdout}), 64'd0);
        pulses = 0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (rx_valid) pulses++;
        end
        chk(pulses == 0, "R8 no strobe while idle", 64'(pulses), 64'd0);

        // R7 R9 slave mode, clocks from the bench
        master = 1'b0;
        slave_run = 1'b1;
        run_case(2'd1, 2'd2, 1'b0, 24'h3C5A96, 24'hE1D2C3, "R7 R9 slave LJ");
        chk(!bclk_oe && !lrclk_oe && sdout_oe, "R7 slave enables",
            64'({bclk_oe, lrclk_oe, sdout_oe}), 64'd1);
        run_case(2'd0, 2'd0, 1'b0, 24'hFEDC01, 24'h0123FE, "R9 slave I2S 16");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule